// File: doc/BRIEF.md
# Segmented Multi-Packet Stream Packer

This block takes a plain byte stream that moves one segment-sized beat at a time, with one packet per beat, and packs it onto a wider bus. The wider bus is divided into equal segments. Each input beat fills exactly one output segment, and segments are filled in order starting from the lowest-order one. Because of this, a packet always begins at byte 0 of some segment. When a packet ends in one segment, the next packet can begin in the following segment of the same output beat. The `NUM_SOP` parameter limits how many packets may begin in a single output beat.

Every output segment carries its own valid, start, end, error and empty-byte-count signals. A single ready signal applies backpressure to the whole output beat. An output beat that is only partly filled is sent when one of three things happens:
- the start limit stops the next packet from joining the beat;
- no input beat is offered in that cycle;
- the beat is complete.

The block is parameterised by bus width, segment count and start limit. The default configuration is 16 bytes, two segments and two starts per beat.

Top module: `msp_stream_packer`

## Requirements
- R1: After reset, `m_valid` and every bit of `m_seg_valid` are low, and `s_ready` is high.
- R2: Every packet comes out in input order, with the same length and the same bytes. Byte 0 of the input beat maps to byte 0 of its segment, and segment k occupies bits `[k*SEG_W +: SEG_W]` of `m_data`.
- R3: A segment marked as start holds only bytes of the new packet, beginning at its byte 0. Any valid segment that is not a start continues a packet that is already open. When a start segment has a valid segment directly below it, that lower segment must carry the end of the previous packet.
- R4: Among the valid segments of one output beat, at most `NUM_SOP` carry a start. With `NUM_SOP = 2`, back-to-back single-beat packets pair up as start+end in both segments.
- R5: Suppose a packet start would exceed the limit. It is then moved to segment 0 of a later beat, and the current beat is sent with its higher segments invalid. With `NUM_SOP = 1`, back-to-back single-beat packets therefore each occupy segment 0 alone.
- R6: The empty count gives the number of unused trailing bytes, in the range 0 to `SEG_BYTES-1`, and only on a segment marked as end. On every other valid segment it is 0.
- R7: The valid segments of a beat are always contiguous from segment 0 upward (a thermometer code).
- R8: While `m_valid` is high and `m_ready` is low, the output beat does not change. `s_ready` is low whenever the accumulator is full and the output register cannot drain.
- R9: The input error bit on a packet's last beat appears on the segment that carries that packet's end.
- R10: A partly filled beat is sent once the input stops offering data, so no packet is left stranded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with `s_valid` |
| s_data | input | SEG_BYTES*8 | Input beat bytes, byte 0 in the low bits |
| s_last | input | 1 | Last beat of the packet |
| s_empty | input | EMPTY_W | Unused trailing bytes of the last beat |
| s_err | input | 1 | Error flag, taken on the last beat |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat accepted |
| m_data | output | BUS_BYTES*8 | Output bus, segment 0 in the low bits |
| m_seg_valid | output | NUM_SEG | Segment holds data |
| m_seg_sop | output | NUM_SEG | Segment starts a packet |
| m_seg_eop | output | NUM_SEG | Segment ends a packet |
| m_seg_empty | output | NUM_SEG*EMPTY_W | Empty count for each segment |
| m_seg_err | output | NUM_SEG | Error flag for each segment, valid with its end |

## Verification
The hardest case to reach is the moment a start is deferred. This needs a beat whose start budget is already used up, with the next input beat being a new packet that arrives while the accumulator is still partly filled. An idle gap or a stall would flush or reshape that beat first.

The bench therefore begins with a run of single-beat packets. During this run input valid is held high and output ready is held high, so the start-limited instance must split every pair and the unlimited instance must pair them. After that run, random packet lengths, input gaps and output stalls exercise backpressure and idle flushes.

// File: rtl/msp_pkg.sv
`timescale 1ns/1ps
package msp_pkg;

   // Reason an accumulated beat is moved to the output register.
   typedef enum logic [1:0] {
      FL_NONE,
      FL_FULL,
      FL_SOPLIM,
      FL_IDLE
   } flush_cause_e;

   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/msp_sop_track.sv
`timescale 1ns/1ps
// Marks whether the next input beat opens a new packet.
module msp_sop_track (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic last,
   output logic in_sop
);

   logic mid_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    mid_q <= 1'b0;
      else if (fire) mid_q <= !last;
   end

   assign in_sop = !mid_q;

endmodule

// File: rtl/msp_flush_ctl.sv
`timescale 1ns/1ps
// Decides when the accumulator hands its beat to the output register
// and whether an input beat can be taken this cycle.
module msp_flush_ctl
   import msp_pkg::*;
#(
   parameter int NUM_SEG = 2,
   parameter int NUM_SOP = 2,
   parameter int CNT_W   = 2
) (
   input  logic [CNT_W-1:0] acc_cnt,
   input  logic [CNT_W-1:0] sop_cnt,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             out_full,
   input  logic             out_ready,
   output logic             in_ready,
   output logic             flush
);

   flush_cause_e cause;
   logic         can_move;
   logic         acc_full;
   logic         acc_some;
   logic         sop_lim;

   assign acc_full = (acc_cnt == CNT_W'(NUM_SEG));
   assign acc_some = (acc_cnt != '0);
   assign sop_lim  = acc_some && in_sop && (sop_cnt >= CNT_W'(NUM_SOP));
   assign can_move = !out_full || out_ready;

   always_comb begin
      cause = FL_NONE;
      if (acc_full)              cause = FL_FULL;
      else if (sop_lim)          cause = FL_SOPLIM;
      else if (acc_some && !in_valid) cause = FL_IDLE;
   end

   assign in_ready = !(cause == FL_FULL || cause == FL_SOPLIM) || can_move;
   assign flush    = (cause != FL_NONE) && can_move;

endmodule

// File: rtl/msp_seg_accum.sv
`timescale 1ns/1ps
// Collects input beats into segment slots, lowest slot first.
module msp_seg_accum #(
   parameter int NUM_SEG = 2,
   parameter int SEG_W   = 64,
   parameter int EMPTY_W = 3,
   parameter int CNT_W   = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take,
   input  logic                       flush,
   input  logic [SEG_W-1:0]           in_data,
   input  logic                       in_last,
   input  logic [EMPTY_W-1:0]         in_empty,
   input  logic                       in_err,
   input  logic                       in_sop,
   output logic [CNT_W-1:0]           acc_cnt,
   output logic [CNT_W-1:0]           sop_cnt,
   output logic [NUM_SEG*SEG_W-1:0]   slot_data,
   output logic [NUM_SEG-1:0]         slot_valid,
   output logic [NUM_SEG-1:0]         slot_sop,
   output logic [NUM_SEG-1:0]         slot_eop,
   output logic [NUM_SEG*EMPTY_W-1:0] slot_empty,
   output logic [NUM_SEG-1:0]         slot_err
);

   logic [CNT_W-1:0] wr_idx;

   assign wr_idx = flush ? '0 : acc_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_cnt <= '0;
         sop_cnt <= '0;
      end else if (flush && take) begin
         acc_cnt <= CNT_W'(1);
         sop_cnt <= CNT_W'(in_sop);
      end else if (flush) begin
         acc_cnt <= '0;
         sop_cnt <= '0;
      end else if (take) begin
         acc_cnt <= acc_cnt + CNT_W'(1);
         sop_cnt <= sop_cnt + CNT_W'(in_sop);
      end
   end

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_slot
      logic wr;
      assign wr = take && (wr_idx == CNT_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_sop[i] <= 1'b0;
            slot_eop[i] <= 1'b0;
            slot_err[i] <= 1'b0;
         end else if (wr) begin
            slot_sop[i] <= in_sop;
            slot_eop[i] <= in_last;
            slot_err[i] <= in_last && in_err;
         end
      end

      always_ff @(posedge clk) begin
         if (wr) begin
            slot_data[i*SEG_W +: SEG_W]     <= in_data;
            slot_empty[i*EMPTY_W +: EMPTY_W] <= in_last ? in_empty : '0;
         end
      end

      assign slot_valid[i] = (CNT_W'(i) < acc_cnt);
   end

endmodule

// File: rtl/msp_out_reg.sv
`timescale 1ns/1ps
// One-deep holding register for the packed output beat.
module msp_out_reg #(
   parameter int NUM_SEG = 2,
   parameter int SEG_W   = 64,
   parameter int EMPTY_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       out_ready,
   input  logic [NUM_SEG*SEG_W-1:0]   slot_data,
   input  logic [NUM_SEG-1:0]         slot_valid,
   input  logic [NUM_SEG-1:0]         slot_sop,
   input  logic [NUM_SEG-1:0]         slot_eop,
   input  logic [NUM_SEG*EMPTY_W-1:0] slot_empty,
   input  logic [NUM_SEG-1:0]         slot_err,
   output logic                       out_full,
   output logic [NUM_SEG*SEG_W-1:0]   m_data,
   output logic [NUM_SEG-1:0]         m_seg_valid,
   output logic [NUM_SEG-1:0]         m_seg_sop,
   output logic [NUM_SEG-1:0]         m_seg_eop,
   output logic [NUM_SEG*EMPTY_W-1:0] m_seg_empty,
   output logic [NUM_SEG-1:0]         m_seg_err
);

   logic [NUM_SEG-1:0] sv_q, sop_q, eop_q, err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_full <= 1'b0;
         sv_q     <= '0;
         sop_q    <= '0;
         eop_q    <= '0;
         err_q    <= '0;
      end else if (flush) begin
         out_full <= 1'b1;
         sv_q     <= slot_valid;
         sop_q    <= slot_sop & slot_valid;
         eop_q    <= slot_eop & slot_valid;
         err_q    <= slot_err & slot_valid;
      end else if (out_ready) begin
         out_full <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (flush) begin
         m_data      <= slot_data;
         m_seg_empty <= slot_empty;
      end
   end

   assign m_seg_valid = out_full ? sv_q  : '0;
   assign m_seg_sop   = out_full ? sop_q : '0;
   assign m_seg_eop   = out_full ? eop_q : '0;
   assign m_seg_err   = out_full ? err_q : '0;

endmodule

// File: rtl/msp_stream_packer.sv
`timescale 1ns/1ps
module msp_stream_packer #(
   parameter  int BUS_BYTES = 16,
   parameter  int NUM_SEG   = 2,
   parameter  int NUM_SOP   = 2,
   localparam int SEG_BYTES = BUS_BYTES / NUM_SEG,
   localparam int SEG_W     = SEG_BYTES * 8,
   localparam int EMPTY_W   = (SEG_BYTES < 2) ? 1 : $clog2(SEG_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       s_valid,
   output logic                       s_ready,
   input  logic [SEG_W-1:0]           s_data,
   input  logic                       s_last,
   input  logic [EMPTY_W-1:0]         s_empty,
   input  logic                       s_err,
   output logic                       m_valid,
   input  logic                       m_ready,
   output logic [BUS_BYTES*8-1:0]     m_data,
   output logic [NUM_SEG-1:0]         m_seg_valid,
   output logic [NUM_SEG-1:0]         m_seg_sop,
   output logic [NUM_SEG-1:0]         m_seg_eop,
   output logic [NUM_SEG*EMPTY_W-1:0] m_seg_empty,
   output logic [NUM_SEG-1:0]         m_seg_err
);

   localparam int CNT_W = msp_pkg::cnt_bits(NUM_SEG);

   if (NUM_SEG < 1 || (BUS_BYTES % NUM_SEG) != 0) begin : g_bad_seg
      $error("BUS_BYTES must split evenly into NUM_SEG segments");
   end
   if (NUM_SOP < 1 || NUM_SOP > NUM_SEG) begin : g_bad_sop
      $error("NUM_SOP must lie between 1 and NUM_SEG");
   end

   logic                       in_sop;
   logic                       take;
   logic                       flush;
   logic                       out_full;
   logic [CNT_W-1:0]           acc_cnt;
   logic [CNT_W-1:0]           sop_cnt;
   logic [NUM_SEG*SEG_W-1:0]   slot_data;
   logic [NUM_SEG-1:0]         slot_valid, slot_sop, slot_eop, slot_err;
   logic [NUM_SEG*EMPTY_W-1:0] slot_empty;

   assign take    = s_valid && s_ready;
   assign m_valid = out_full;

   msp_sop_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (take),
      .last   (s_last),
      .in_sop (in_sop)
   );

   msp_flush_ctl #(
      .NUM_SEG (NUM_SEG),
      .NUM_SOP (NUM_SOP),
      .CNT_W   (CNT_W)
   ) u_ctl (
      .acc_cnt   (acc_cnt),
      .sop_cnt   (sop_cnt),
      .in_valid  (s_valid),
      .in_sop    (in_sop),
      .out_full  (out_full),
      .out_ready (m_ready),
      .in_ready  (s_ready),
      .flush     (flush)
   );

   msp_seg_accum #(
      .NUM_SEG (NUM_SEG),
      .SEG_W   (SEG_W),
      .EMPTY_W (EMPTY_W),
      .CNT_W   (CNT_W)
   ) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .flush      (flush),
      .in_data    (s_data),
      .in_last    (s_last),
      .in_empty   (s_empty),
      .in_err     (s_err),
      .in_sop     (in_sop),
      .acc_cnt    (acc_cnt),
      .sop_cnt    (sop_cnt),
      .slot_data  (slot_data),
      .slot_valid (slot_valid),
      .slot_sop   (slot_sop),
      .slot_eop   (slot_eop),
      .slot_empty (slot_empty),
      .slot_err   (slot_err)
   );

   msp_out_reg #(
      .NUM_SEG (NUM_SEG),
      .SEG_W   (SEG_W),
      .EMPTY_W (EMPTY_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .out_ready   (m_ready),
      .slot_data   (slot_data),
      .slot_valid  (slot_valid),
      .slot_sop    (slot_sop),
      .slot_eop    (slot_eop),
      .slot_empty  (slot_empty),
      .slot_err    (slot_err),
      .out_full    (out_full),
      .m_data      (m_data),
      .m_seg_valid (m_seg_valid),
      .m_seg_sop   (m_seg_sop),
      .m_seg_eop   (m_seg_eop),
      .m_seg_empty (m_seg_empty),
      .m_seg_err   (m_seg_err)
   );

endmodule

// File: rtl/msp_packer_chk.sv
`timescale 1ns/1ps
module msp_packer_chk #(
   parameter int NUM_SEG   = 2,
   parameter int NUM_SOP   = 2,
   parameter int SEG_BYTES = 8,
   parameter int BUS_BYTES = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         s_ready,
   input logic                         m_valid,
   input logic                         m_ready,
   input logic [BUS_BYTES*8-1:0]       m_data,
   input logic [NUM_SEG-1:0]           m_seg_valid,
   input logic [NUM_SEG-1:0]           m_seg_sop,
   input logic [NUM_SEG-1:0]           m_seg_eop,
   input logic [NUM_SEG*((SEG_BYTES < 2) ? 1 : $clog2(SEG_BYTES))-1:0] m_seg_empty,
   input logic [msp_pkg::cnt_bits(NUM_SEG)-1:0] acc_cnt
);

   localparam int EMPTY_W = (SEG_BYTES < 2) ? 1 : $clog2(SEG_BYTES);
   localparam int CNT_W   = msp_pkg::cnt_bits(NUM_SEG);

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!m_valid && m_seg_valid == '0));

   a_r4_sop_limit: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> ($countones(m_seg_sop & m_seg_valid) <= NUM_SOP));

   a_r7_thermo: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (((m_seg_valid + NUM_SEG'(1)) & m_seg_valid) == '0));

   a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> (m_seg_valid == '0));

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_seg_valid)));

   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_cnt == CNT_W'(NUM_SEG) && m_valid && !m_ready) |-> !s_ready);

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (m_seg_valid[i] && !m_seg_eop[i]) |-> (m_seg_empty[i*EMPTY_W +: EMPTY_W] == '0));
      if (i > 0) begin : g_up
         a_r3_start_after_end: assert property (@(posedge clk) disable iff (!rst_n)
            (m_seg_valid[i] && m_seg_sop[i] && m_seg_valid[i-1]) |-> m_seg_eop[i-1]);
      end
   end

endmodule

bind msp_stream_packer msp_packer_chk #(
   .NUM_SEG   (NUM_SEG),
   .NUM_SOP   (NUM_SOP),
   .SEG_BYTES (SEG_BYTES),
   .BUS_BYTES (BUS_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .s_ready     (s_ready),
   .m_valid     (m_valid),
   .m_ready     (m_ready),
   .m_data      (m_data),
   .m_seg_valid (m_seg_valid),
   .m_seg_sop   (m_seg_sop),
   .m_seg_eop   (m_seg_eop),
   .m_seg_empty (m_seg_empty),
   .acc_cnt     (acc_cnt)
);

// File: tb/sim_msp_stream_packer.sv
`timescale 1ns/1ps
module sim_msp_stream_packer;

   localparam int NPKT = 300;
   localparam int SB   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   bit   go = 1'b0;
   int   errors = 0;
   int   checks = 0;
   int   lanes_done = 0;
   int   plen[NPKT];

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   task automatic lane_finished();
      lanes_done++;
   endtask

   function automatic logic [7:0] pbyte(input int p, input int i);
      return 8'(p * 37 + i * 11 + 5);
   endfunction

   // Lane 0: start limit 1. Lane 1: start limit 2.
   for (genvar k = 0; k < 2; k++) begin : g_lane
      logic         s_valid, s_ready, s_last, s_err;
      logic [63:0]  s_data;
      logic [2:0]   s_empty;
      logic         m_valid, m_ready;
      logic [127:0] m_data;
      logic [1:0]   m_seg_valid, m_seg_sop, m_seg_eop, m_seg_err;
      logic [5:0]   m_seg_empty;
      logic [7:0]   rbuf[$];

      msp_stream_packer #(.BUS_BYTES(16), .NUM_SEG(2), .NUM_SOP(k + 1)) u0 (
         .clk(clk), .rst_n(rst_n),
         .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
         .s_empty(s_empty), .s_err(s_err),
         .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
         .m_seg_valid(m_seg_valid), .m_seg_sop(m_seg_sop), .m_seg_eop(m_seg_eop),
         .m_seg_empty(m_seg_empty), .m_seg_err(m_seg_err)
      );

      initial begin
         int tx_pkt, tx_beat, rx_pkt, one_seg, two_sop, rem;
         bit fire, in_pkt, held;
         logic [127:0] hd;
         logic [1:0]   hv;
         tx_pkt = 0; tx_beat = 0; rx_pkt = 0; one_seg = 0; two_sop = 0;
         fire = 0; in_pkt = 0; held = 0; hd = '0; hv = '0;
         s_valid = 0; s_last = 0; s_err = 0; s_data = '0; s_empty = '0; m_ready = 0;
         wait (go);
         #1;
         chk(!m_valid && m_seg_valid == 2'b00 && s_ready, "R1",
             $sformatf("lane%0d reset m_valid=%0b seg_valid=%b s_ready=%0b exp 0/00/1",
                       k, m_valid, m_seg_valid, s_ready));
         while (rx_pkt < NPKT) begin
            @(negedge clk);
            if (fire) begin
               tx_beat++;
               if (tx_beat * SB >= plen[tx_pkt]) begin tx_pkt++; tx_beat = 0; end
            end
            m_ready = (tx_pkt < 8) ? 1'b1 : ($urandom % 3 != 0);
            #1;
            if (held)
               chk(m_valid && m_data == hd && m_seg_valid == hv, "R8",
                   $sformatf("lane%0d stalled beat changed seg_valid=%b exp %b", k, m_seg_valid, hv));
            held = m_valid && !m_ready;
            hd = m_data; hv = m_seg_valid;
            if (m_valid && m_ready) begin
               chk($countones(m_seg_sop & m_seg_valid) <= k + 1, "R4",
                   $sformatf("lane%0d starts=%0d exp <=%0d", k,
                             $countones(m_seg_sop & m_seg_valid), k + 1));
               chk(m_seg_valid != 2'b10 && m_seg_valid != 2'b00, "R7",
                   $sformatf("lane%0d seg_valid=%b exp 01 or 11", k, m_seg_valid));
               if (m_seg_valid == 2'b01 && m_seg_sop[0] && m_seg_eop[0]) one_seg++;
               if ((m_seg_sop & m_seg_valid) == 2'b11) two_sop++;
               for (int j = 0; j < 2; j++) begin
                  if (m_seg_valid[j]) begin
                     if (m_seg_sop[j]) begin
                        chk(!in_pkt, "R3", $sformatf("lane%0d start in open packet, exp closed", k));
                        rbuf.delete();
                        in_pkt = 1;
                     end else begin
                        chk(in_pkt, "R3", $sformatf("lane%0d continuation with no open packet", k));
                     end
                     if (!m_seg_eop[j]) begin
                        chk(m_seg_empty[j*3 +: 3] == 3'd0, "R6",
                            $sformatf("lane%0d empty=%0d exp 0", k, m_seg_empty[j*3 +: 3]));
                        for (int b = 0; b < SB; b++) rbuf.push_back(m_data[j*64 + b*8 +: 8]);
                     end else begin
                        for (int b = 0; b < SB - int'(m_seg_empty[j*3 +: 3]); b++)
                           rbuf.push_back(m_data[j*64 + b*8 +: 8]);
                        chk(rbuf.size() == plen[rx_pkt], "R2",
                            $sformatf("lane%0d pkt%0d len=%0d exp %0d", k, rx_pkt,
                                      rbuf.size(), plen[rx_pkt]));
                        begin
                           int bad;
                           bad = -1;
                           for (int b = 0; b < rbuf.size() && b < plen[rx_pkt]; b++)
                              if (bad < 0 && rbuf[b] != pbyte(rx_pkt, b)) bad = b;
                           chk(bad < 0, "R2",
                               $sformatf("lane%0d pkt%0d byte %0d act=%0h exp=%0h", k, rx_pkt, bad,
                                         (bad < 0) ? 8'h0 : rbuf[bad],
                                         (bad < 0) ? 8'h0 : pbyte(rx_pkt, bad)));
                        end
                        chk(m_seg_err[j] == (rx_pkt % 5 == 3), "R9",
                            $sformatf("lane%0d pkt%0d err=%0b exp %0b", k, rx_pkt,
                                      m_seg_err[j], rx_pkt % 5 == 3));
                        rx_pkt++;
                        in_pkt = 0;
                     end
                  end
               end
            end
            if (!s_valid || fire) begin
               if (tx_pkt < NPKT && (tx_pkt < 6 || $urandom % 4 != 0)) begin
                  rem = plen[tx_pkt] - tx_beat * SB;
                  s_valid = 1;
                  s_last  = (rem <= SB);
                  s_empty = (rem <= SB) ? 3'(SB - rem) : 3'd0;
                  s_err   = (rem <= SB) && (tx_pkt % 5 == 3);
                  for (int b = 0; b < SB; b++)
                     s_data[b*8 +: 8] = (b < rem) ? pbyte(tx_pkt, tx_beat * SB + b) : 8'h00;
               end else begin
                  s_valid = 0;
               end
            end
            #1;
            fire = s_valid && s_ready;
         end
         if (k == 0)
            chk(one_seg >= 6, "R5", $sformatf("lane0 lone start beats=%0d exp >=6", one_seg));
         else
            chk(two_sop >= 3, "R4", $sformatf("lane1 paired start beats=%0d exp >=3", two_sop));
         lane_finished();
      end
   end

   initial begin
      void'($urandom(32'd4711));
      plen[0] = 8; plen[1] = 3; plen[2] = 8; plen[3] = 1; plen[4] = 8; plen[5] = 5;
      plen[6] = 9; plen[7] = 16; plen[8] = 17; plen[9] = 64;
      for (int i = 10; i < NPKT; i++) plen[i] = 1 + int'($urandom % 40);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      go = 1'b1;
      fork
         wait (lanes_done == 2);
         repeat (150000) @(posedge clk);
      join_any
      chk(lanes_done == 2, "R10",
          $sformatf("lanes finished=%0d exp 2 (packets stranded or hung)", lanes_done));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule